// File: doc/BRIEF.md
# Streaming Profile Linear Detrender

The detrender receives a profile of pixel intensities, one signed sample per clock. It fits a straight line `slope*i + intercept` through the samples by ordinary least squares, with `i` the position of the sample in the profile. It then plays the same samples back in index order with that line removed, so that a following phase estimator sees only the oscillating part of the profile. The profile length `NS` is fixed when the block is built and defaults to 20.

The block contains no divider. The index variance and the profile length are constants for a given `NS`. Each division by one of them is a multiply by a precomputed reciprocal followed by an arithmetic right shift. Samples, slope and the two reciprocal constants are 18-bit signed operands. Only the accumulators and the covariance term run wider.

Two sample banks alternate between profiles. A new profile can therefore begin in the clock cycle after the previous profile's last sample, and the corrected bursts of successive profiles follow one another without loss.

Top module: `profile_detrend`

## Requirements
- R1: While reset is high and after reset is released, `o_valid` and `o_last` are 0 and `o_data` is 0 until a profile completes.
- R2: A sample with `s_valid` and `s_first` both high is index 0 of a new profile. Each following accepted sample takes the next index, and the profile is complete when index NS-1 is accepted.
- R3: A sample with `s_valid` high and `s_first` low is ignored when no profile is open, and it produces no output. A `s_first` sample that arrives while a profile is open discards the partial profile and starts a new one at index 0.
- R4: Clock cycles with `s_valid` low neither advance the index nor change the sums, so gaps between samples leave the result unchanged.
- R5: The doubled covariance is `cov2 = 2*Σ(i*I[i]) - (NS-1)*ΣI[i]`. The slope is `(cov2*RV) >>> SV`, where `>>>` is an arithmetic shift that rounds toward minus infinity and `RV = floor(2^SV / (NS*(NS*NS-1)/6))`. By default SV = 26.
- R6: The mean is `(ΣI[i]*RM) >>> SM`, where `RM = floor(2^SM / NS)`; by default SM = 20. The intercept is `mean - ((slope*(NS-1)) >>> 1)`.
- R7: Corrected sample j is `I[j] - intercept - slope*j`. The NS corrected samples leave in order j = 0..NS-1 on consecutive cycles with `o_valid` high, and `o_last` is high only on j = NS-1. `o_slope` and `o_icpt` carry the fit of that profile and are held for the whole burst.
- R8: Corrected sample j is valid 4+j clock edges after the edge that accepted the profile's last sample.
- R9: A new profile can start on the cycle right after the last sample of the previous one. Every profile of a back-to-back run gets its complete, correct burst.
- R10: A profile whose samples are all equal gives a slope of exactly 0.
- R11: Full-scale ascending ramps, descending ramps and steps, spanning the whole 18-bit input range, give results that match R5 to R7 exactly, with no overflow in any sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Sample strobe |
| s_first | input | 1 | Marks index 0 of a profile |
| s_data | input | DW (18) | Signed intensity sample |
| o_valid | output | 1 | Corrected sample strobe |
| o_last | output | 1 | Marks the last corrected sample of a profile |
| o_data | output | DW+clog2(NS)+2 (25) | Signed corrected sample |
| o_slope | output | DW (18) | Signed fitted slope for the current burst |
| o_icpt | output | DW+clog2(NS)+2 (25) | Signed fitted intercept for the current burst |

## Verification
The last sample is accepted on some clock edge. From that edge, the sums take one stage, the slope and mean a second, the intercept a third and the replay start a fourth. Corrected sample j is therefore due exactly 4+j edges later, and the slope and intercept travel with every beat of the burst. The driver stamps the cycle in which each profile's last sample will be accepted. The monitor samples on the falling edge, compares the beats in order against a queue of reference values computed from the formulas, and checks that the first beat of each burst lands exactly four cycles after its stamp. Back-to-back profiles, gaps, aborted profiles and stray samples all pass through the same queue, so a lost beat, an extra beat or a beat in the wrong cycle shows up as a mismatch.

// File: rtl/profile_detrend_pkg.sv
package profile_detrend_pkg;

    // State of the sample collector.
    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_OPEN = 1'b1
    } acc_state_e;

    // Doubled index variance: 2 * sum((i - mean_i)^2) = n*(n*n-1)/6.
    function automatic int var2_of(input int n);
        return (n * (n * n - 1)) / 6;
    endfunction

    // Scaled reciprocal floor(2^sh / d).
    function automatic int recip_of(input int d, input int sh);
        return int'((longint'(1) << sh) / longint'(d));
    endfunction

endpackage

// File: rtl/profile_detrend_accum.sv
module profile_detrend_accum
    import profile_detrend_pkg::*;
#(
    parameter int NS  = 20,
    parameter int DW  = 18,
    parameter int IW  = 5,
    parameter int SYW = 23,
    parameter int SIW = 28
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  s_valid,
    input  logic                  s_first,
    input  logic signed [DW-1:0]  s_data,
    output logic                  wr_en,
    output logic                  wr_bank,
    output logic [IW-1:0]         wr_idx,
    output logic signed [DW-1:0]  wr_data,
    output logic                  done,
    output logic                  done_bank,
    output logic signed [SYW-1:0] sum_y,
    output logic signed [SIW-1:0] sum_iy
);

    acc_state_e            st;
    logic [IW-1:0]         idx;
    logic                  bank;
    logic                  begin_p;
    logic                  take;
    logic                  last_p;
    logic [IW-1:0]         cur_idx;
    logic signed [SIW-1:0] iy_term;

    assign begin_p = s_valid && s_first;
    assign take    = s_valid && (s_first || (st == ACC_OPEN));
    assign cur_idx = begin_p ? '0 : idx;
    assign last_p  = take && (cur_idx == IW'(NS - 1));
    assign iy_term = SIW'(s_data) * SIW'(signed'({1'b0, cur_idx}));

    assign wr_en   = take;
    assign wr_bank = bank;
    assign wr_idx  = cur_idx;
    assign wr_data = s_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ACC_IDLE;
            idx       <= '0;
            bank      <= 1'b0;
            done      <= 1'b0;
            done_bank <= 1'b0;
            sum_y     <= '0;
            sum_iy    <= '0;
        end else begin
            done <= 1'b0;
            if (take) begin
                sum_y  <= (begin_p ? '0 : sum_y) + SYW'(s_data);
                sum_iy <= (begin_p ? '0 : sum_iy) + iy_term;
                if (last_p) begin
                    st        <= ACC_IDLE;
                    idx       <= '0;
                    done      <= 1'b1;
                    done_bank <= bank;
                    bank      <= ~bank;
                end else begin
                    st  <= ACC_OPEN;
                    idx <= cur_idx + IW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/profile_detrend_solve.sv
module profile_detrend_solve #(
    parameter int NS    = 20,
    parameter int DW    = 18,
    parameter int IW    = 5,
    parameter int SYW   = 23,
    parameter int SIW   = 28,
    parameter int OW    = 25,
    parameter int RW    = 18,
    parameter int SH_V  = 26,
    parameter int RCP_V = 50457,
    parameter int SH_M  = 20,
    parameter int RCP_M = 52428
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_vld,
    input  logic                  in_bank,
    input  logic signed [SYW-1:0] sum_y,
    input  logic signed [SIW-1:0] sum_iy,
    output logic                  fit_vld,
    output logic                  fit_bank,
    output logic signed [DW-1:0]  fit_slope,
    output logic signed [OW-1:0]  fit_icpt
);

    localparam int CVW = SIW + 2;
    localparam int SPW = CVW + RW;
    localparam int MPW = SYW + RW;
    localparam logic signed [RW-1:0] RV_S = RW'(RCP_V);
    localparam logic signed [RW-1:0] RM_S = RW'(RCP_M);
    localparam logic signed [IW:0]   NM1  = (IW + 1)'(NS - 1);

    // Stage 1: doubled covariance, slope and mean by multiply and shift.
    logic signed [CVW-1:0] cov2;
    logic signed [SPW-1:0] sl_prod;
    logic signed [MPW-1:0] mn_prod;

    assign cov2    = (CVW'(sum_iy) <<< 1) - CVW'(sum_y) * CVW'(NM1);
    assign sl_prod = SPW'(cov2) * SPW'(RV_S);
    assign mn_prod = MPW'(sum_y) * MPW'(RM_S);

    logic                 s1_vld;
    logic                 s1_bank;
    logic signed [DW-1:0] s1_slope;
    logic signed [DW-1:0] s1_mean;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s1_bank  <= 1'b0;
            s1_slope <= '0;
            s1_mean  <= '0;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_bank  <= in_bank;
                s1_slope <= DW'(sl_prod >>> SH_V);
                s1_mean  <= DW'(mn_prod >>> SH_M);
            end
        end
    end

    // Stage 2: intercept = mean - slope*(NS-1)/2.
    logic signed [OW-1:0] hx_prod;
    logic signed [OW-1:0] icpt_c;

    assign hx_prod = OW'(s1_slope) * OW'(NM1);
    assign icpt_c  = OW'(s1_mean) - (hx_prod >>> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            fit_vld   <= 1'b0;
            fit_bank  <= 1'b0;
            fit_slope <= '0;
            fit_icpt  <= '0;
        end else begin
            fit_vld <= s1_vld;
            if (s1_vld) begin
                fit_bank  <= s1_bank;
                fit_slope <= s1_slope;
                fit_icpt  <= icpt_c;
            end
        end
    end

endmodule

// File: rtl/profile_detrend_replay.sv
module profile_detrend_replay #(
    parameter int NS = 20,
    parameter int DW = 18,
    parameter int IW = 5,
    parameter int OW = 25
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_bank,
    input  logic [IW-1:0]        wr_idx,
    input  logic signed [DW-1:0] wr_data,
    input  logic                 fit_vld,
    input  logic                 fit_bank,
    input  logic signed [DW-1:0] fit_slope,
    input  logic signed [OW-1:0] fit_icpt,
    output logic                 o_valid,
    output logic                 o_last,
    output logic signed [OW-1:0] o_data,
    output logic signed [DW-1:0] o_slope,
    output logic signed [OW-1:0] o_icpt
);

    // Two banks: one fills while the other is replayed.
    logic signed [DW-1:0] mem [2][NS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_bank][wr_idx] <= wr_data;
    end

    logic                 rp_on;
    logic [IW-1:0]        rp_idx;
    logic                 rp_bank;
    logic signed [DW-1:0] rp_slope;
    logic signed [OW-1:0] rp_icpt;
    logic signed [OW-1:0] cur_smp;
    logic signed [OW-1:0] ramp;
    logic                 at_end;

    assign cur_smp = OW'(mem[rp_bank][rp_idx]);
    assign ramp    = OW'(rp_slope) * OW'(signed'({1'b0, rp_idx}));
    assign at_end  = (rp_idx == IW'(NS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rp_on    <= 1'b0;
            rp_idx   <= '0;
            rp_bank  <= 1'b0;
            rp_slope <= '0;
            rp_icpt  <= '0;
            o_valid  <= 1'b0;
            o_last   <= 1'b0;
            o_data   <= '0;
            o_slope  <= '0;
            o_icpt   <= '0;
        end else begin
            o_valid <= rp_on;
            o_last  <= rp_on && at_end;
            if (rp_on) begin
                o_data  <= cur_smp - rp_icpt - ramp;
                o_slope <= rp_slope;
                o_icpt  <= rp_icpt;
            end
            if (fit_vld) begin
                rp_on    <= 1'b1;
                rp_idx   <= '0;
                rp_bank  <= fit_bank;
                rp_slope <= fit_slope;
                rp_icpt  <= fit_icpt;
            end else if (rp_on) begin
                if (at_end) rp_on  <= 1'b0;
                else        rp_idx <= rp_idx + IW'(1);
            end
        end
    end

endmodule

// File: rtl/profile_detrend.sv
module profile_detrend
    import profile_detrend_pkg::*;
#(
    parameter int NS    = 20,
    parameter int DW    = 18,
    parameter int RW    = 18,
    parameter int SH_V  = 26,
    parameter int SH_M  = 20,
    parameter int RCP_V = recip_of(var2_of(NS), SH_V),
    parameter int RCP_M = recip_of(NS, SH_M)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   s_valid,
    input  logic                                   s_first,
    input  logic signed [DW-1:0]                   s_data,
    output logic                                   o_valid,
    output logic                                   o_last,
    output logic signed [DW+$clog2(NS)+1:0]        o_data,
    output logic signed [DW-1:0]                   o_slope,
    output logic signed [DW+$clog2(NS)+1:0]        o_icpt
);

    localparam int IW  = $clog2(NS);
    localparam int SYW = DW + IW;
    localparam int SIW = DW + 2 * IW;
    localparam int OW  = DW + IW + 2;

    logic                  wr_en;
    logic                  wr_bank;
    logic [IW-1:0]         wr_idx;
    logic signed [DW-1:0]  wr_data;
    logic                  acc_done;
    logic                  acc_bank;
    logic signed [SYW-1:0] sum_y;
    logic signed [SIW-1:0] sum_iy;
    logic                  fit_vld;
    logic                  fit_bank;
    logic signed [DW-1:0]  fit_slope;
    logic signed [OW-1:0]  fit_icpt;

    profile_detrend_accum #(
        .NS(NS), .DW(DW), .IW(IW), .SYW(SYW), .SIW(SIW)
    ) u_accum (
        .clk(clk), .rst(rst),
        .s_valid(s_valid), .s_first(s_first), .s_data(s_data),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(acc_done), .done_bank(acc_bank),
        .sum_y(sum_y), .sum_iy(sum_iy)
    );

    profile_detrend_solve #(
        .NS(NS), .DW(DW), .IW(IW), .SYW(SYW), .SIW(SIW), .OW(OW), .RW(RW),
        .SH_V(SH_V), .RCP_V(RCP_V), .SH_M(SH_M), .RCP_M(RCP_M)
    ) u_solve (
        .clk(clk), .rst(rst),
        .in_vld(acc_done), .in_bank(acc_bank),
        .sum_y(sum_y), .sum_iy(sum_iy),
        .fit_vld(fit_vld), .fit_bank(fit_bank),
        .fit_slope(fit_slope), .fit_icpt(fit_icpt)
    );

    profile_detrend_replay #(
        .NS(NS), .DW(DW), .IW(IW), .OW(OW)
    ) u_replay (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx), .wr_data(wr_data),
        .fit_vld(fit_vld), .fit_bank(fit_bank),
        .fit_slope(fit_slope), .fit_icpt(fit_icpt),
        .o_valid(o_valid), .o_last(o_last), .o_data(o_data),
        .o_slope(o_slope), .o_icpt(o_icpt)
    );

endmodule

// File: rtl/profile_detrend_chk.sv
module profile_detrend_chk #(
    parameter int NS = 20,
    parameter int DW = 18,
    parameter int OW = 25
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 o_valid,
    input logic                 o_last,
    input logic signed [DW-1:0] o_slope,
    input logic signed [OW-1:0] o_icpt,
    input logic                 acc_done
);

    int bcnt;
    int gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt <= 0;
            gap  <= NS;
        end else begin
            if (o_valid) bcnt <= o_last ? 0 : bcnt + 1;
            if (acc_done)     gap <= 1;
            else if (gap < NS) gap <= gap + 1;
        end
    end

    // R7: o_last only inside a valid beat
    p_last_in_valid_r7: assert property (@(posedge clk) disable iff (rst)
        o_last |-> o_valid);

    // R7: a burst has no holes
    p_burst_contig_r7: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_last) |=> o_valid);

    // R7: fit values held across a burst
    p_fit_held_r7: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_last) |=> ($stable(o_slope) && $stable(o_icpt)));

    // R7: the last flag falls on beat NS-1
    p_burst_len_r7: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_last) |-> (bcnt == NS - 1));

    // R8: first corrected beat four cycles after completion
    p_latency_r8: assert property (@(posedge clk) disable iff (rst)
        acc_done |-> ##4 o_valid);

    // R9: completions are at least NS cycles apart
    p_done_gap_r9: assert property (@(posedge clk) disable iff (rst)
        acc_done |-> (gap >= NS));

endmodule

bind profile_detrend profile_detrend_chk #(.NS(NS), .DW(DW), .OW(OW)) u_chk (
    .clk(clk), .rst(rst), .o_valid(o_valid), .o_last(o_last),
    .o_slope(o_slope), .o_icpt(o_icpt), .acc_done(acc_done)
);

// File: tb/profile_detrend_tb_top.sv
`timescale 1ns/1ps
module profile_detrend_tb_top;

    localparam int NS   = 20;
    localparam int DW   = 18;
    localparam int SH_V = 26;
    localparam int SH_M = 20;
    localparam int IW   = $clog2(NS);
    localparam int OW   = DW + IW + 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 s_valid = 1'b0;
    logic                 s_first = 1'b0;
    logic signed [DW-1:0] s_data = '0;
    logic                 o_valid;
    logic                 o_last;
    logic signed [OW-1:0] o_data;
    logic signed [DW-1:0] o_slope;
    logic signed [OW-1:0] o_icpt;

    always #2.5 clk = ~clk;

    profile_detrend #(.NS(NS), .DW(DW), .SH_V(SH_V), .SH_M(SH_M)) dut_i (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_first(s_first), .s_data(s_data),
        .o_valid(o_valid), .o_last(o_last), .o_data(o_data),
        .o_slope(o_slope), .o_icpt(o_icpt)
    );

    typedef struct {
        longint data;
        longint slope;
        longint icpt;
        int     idx;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    longint lat_q[$];
    longint cyc = 0;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     finished = 1'b0;
    exp_t   e;
    longint t0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string msg);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // Reference model built from R5, R6, R7.
    task automatic push_expect(input longint p[NS], input string tag);
        longint sy = 0, siy = 0, cov2, var2, rv, rm, slope, mean, icpt;
        for (int j = 0; j < NS; j++) begin
            sy  += p[j];
            siy += longint'(j) * p[j];
        end
        cov2  = 2 * siy - longint'(NS - 1) * sy;
        var2  = (longint'(NS) * (NS * NS - 1)) / 6;
        rv    = (longint'(1) <<< SH_V) / var2;
        rm    = (longint'(1) <<< SH_M) / NS;
        slope = (cov2 * rv) >>> SH_V;
        mean  = (sy * rm) >>> SH_M;
        icpt  = mean - ((slope * (NS - 1)) >>> 1);
        for (int j = 0; j < NS; j++)
            sb_q.push_back('{data: p[j] - icpt - slope * j, slope: slope,
                             icpt: icpt, idx: j, tag: tag});
    endtask

    task automatic drive(input bit v, input bit f, input longint d);
        @(negedge clk);
        s_valid = v;
        s_first = f;
        s_data  = DW'(d);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 0);
    endtask

    task automatic send_profile(input longint p[NS], input string tag, input int gap);
        push_expect(p, tag);
        for (int j = 0; j < NS; j++) begin
            drive(1'b1, j == 0, p[j]);
            if (j == NS - 1) lat_q.push_back(cyc + 1);
            for (int g = 0; g < gap; g++) drive(1'b0, 1'b0, 0);
        end
    endtask

    task automatic rand_fill(output longint p[NS]);
        for (int j = 0; j < NS; j++)
            p[j] = longint'($urandom_range(262143, 0)) - 131072;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && o_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, $sformatf("R3 unexpected beat: got data=%0d expected no output", o_data));
            end else begin
                e = sb_q.pop_front();
                chk(longint'(o_data) == e.data,
                    $sformatf("%s R7 beat %0d data: got %0d expected %0d", e.tag, e.idx, o_data, e.data));
                chk(longint'(o_slope) == e.slope,
                    $sformatf("%s R5 beat %0d slope: got %0d expected %0d", e.tag, e.idx, o_slope, e.slope));
                chk(longint'(o_icpt) == e.icpt,
                    $sformatf("%s R6 beat %0d intercept: got %0d expected %0d", e.tag, e.idx, o_icpt, e.icpt));
                chk(o_last == (e.idx == NS - 1),
                    $sformatf("%s R7 beat %0d last flag: got %0b expected %0b", e.tag, e.idx, o_last, e.idx == NS - 1));
                if (e.tag == "R10")
                    chk(o_slope == 0, $sformatf("R10 constant profile slope: got %0d expected 0", o_slope));
                if (e.idx == 0) begin
                    if (lat_q.size() == 0) begin
                        chk(1'b0, "R8 burst start with no stamped profile: got 1 expected 0");
                    end else begin
                        t0 = lat_q.pop_front();
                        chk(cyc == t0 + 4,
                            $sformatf("R8 first beat cycle: got %0d expected %0d", cyc, t0 + 4));
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        longint p[NS];
        repeat (4) @(negedge clk);
        chk(o_valid == 0 && o_last == 0,
            $sformatf("R1 in reset: got valid=%0b last=%0b expected 0 0", o_valid, o_last));
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(o_valid == 0 && o_last == 0 && o_data == 0,
            $sformatf("R1 after reset: got valid=%0b last=%0b data=%0d expected 0 0 0", o_valid, o_last, o_data));

        // R10: constant profiles
        for (int j = 0; j < NS; j++) p[j] = 1000;
        send_profile(p, "R10", 0); idle(30);
        for (int j = 0; j < NS; j++) p[j] = -131072;
        send_profile(p, "R10", 0); idle(30);

        // R11: full-scale ramps and step
        for (int j = 0; j < NS; j++) p[j] = -131072 + j * 13797;
        send_profile(p, "R11", 0); idle(30);
        for (int j = 0; j < NS; j++) p[j] = 131071 - j * 13797;
        send_profile(p, "R11", 0); idle(30);
        for (int j = 0; j < NS; j++) p[j] = (j < NS / 2) ? 131071 : -131072;
        send_profile(p, "R11", 0); idle(30);

        // R2: isolated random profiles
        for (int k = 0; k < 5; k++) begin
            rand_fill(p);
            send_profile(p, "R2", 0); idle(30);
        end

        // R4: gaps between samples
        rand_fill(p); send_profile(p, "R4", 2);
        rand_fill(p); send_profile(p, "R4", 1);
        idle(30);

        // R9: back-to-back profiles
        for (int k = 0; k < 6; k++) begin
            rand_fill(p);
            send_profile(p, "R9", 0);
        end
        idle(30);

        // R3: stray samples, aborted profile, restart
        drive(1'b1, 1'b0, 12345); drive(1'b1, 1'b0, -999); drive(1'b1, 1'b0, 4242);
        drive(1'b1, 1'b1, 777);
        for (int k = 0; k < 6; k++) drive(1'b1, 1'b0, 50000 - k * 7000);
        rand_fill(p); send_profile(p, "R3", 0);
        for (int k = 0; k < 5; k++) drive(1'b1, 1'b0, 100000);
        idle(30);

        idle(40);
        chk(sb_q.size() == 0,
            $sformatf("R9 beats left undelivered: got %0d expected 0", sb_q.size()));
        chk(lat_q.size() == 0,
            $sformatf("R8 bursts never started: got %0d expected 0", lat_q.size()));
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R8 watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

endmodule